// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block moves bytes between an I/O device and memory on behalf of the processor. Each of its four channels holds a 16-bit running address, a 16-bit byte count and a page value for the upper address bits. A device asks for service on its request line. The controller then requests the system bus with HOLD. Once HLDA comes back, it acknowledges the chosen channel and runs one bus cycle per clock. Each bus cycle moves one byte, with a read strobe and a write strobe driven as a pair.

Software programs the channels through a small write port. The port also takes a software request register, a mask register that changes one channel at a time, and a mask register that loads all four masks at once. A status vector reports terminal count and the live request state of every channel. Each channel runs in one of three modes. Block mode moves a whole block for one request. Single mode moves one byte per request. Demand mode moves bytes for as long as the request stays high.

Top module: `dma_ctrl`

## Requirements
- R1: While a bus cycle runs, `addr_o` equals the channel's page value (upper bits) joined to its 16-bit address. The address starts at the programmed value and rises by one after every byte. It wraps from FFFF to 0000 without changing the page.
- R2: Programming a count of N moves exactly N bytes. Status bit [c] (terminal count) sets when the last byte of channel c is moved. A channel whose count is zero never starts. Writing a new count clears that channel's terminal-count bit.
- R3: After reset, HOLD, every acknowledge and every strobe are low. HOLD rises when an unmasked channel is requesting. No acknowledge and no bus cycle appear until HLDA has been sampled high.
- R4: At most one acknowledge is high at a time, and only for the channel being served. Config bit 10 sets the direction: 1 drives `io_rd_o` with `mem_wr_o`, and 0 drives `mem_rd_o` with `io_wr_o`.
- R5: Block mode (config bits [9:8] = 2 or 3) moves the whole remaining count for one request, even if the request drops or another channel requests during the block.
- R6: Single mode (config bits [9:8] = 1) moves one byte per request and then releases HOLD. The next request continues from the next address with no reprogramming.
- R7: Demand mode (config bits [9:8] = 0) moves bytes while the request is high and stops when it falls, keeping address and count. When the request rises again, the transfer resumes at the next address.
- R8: Status bits [7:4] show, for each channel, its request line OR its pending software request, whether or not the channel is masked.
- R9: A write to address 4'hC with data bit 2 set raises a software request for the channel named by data [1:0]. The software request behaves like a held request line until the service it starts has ended, and is then cleared.
- R10: All masks are set after reset. A write to 4'hD masks (data bit 2 = 1) or unmasks (data bit 2 = 0) the channel named by data [1:0]. A masked channel is never started.
- R11: A write to 4'hE loads all four masks at once from data [3:0], with bit c masking channel c.
- R12: When several unmasked channels are requesting, the lowest-numbered channel is served first. HOLD drops for at least one cycle after every service before the next channel is chosen.

Register map: address bits [3:2] select the function and bits [1:0] select the channel. Function 0 loads the address, function 1 loads the count, and function 2 loads the config (page in [7:0], mode in [9:8], direction in [10]). Function 3 holds the control registers at 4'hC, 4'hD and 4'hE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: function [3:2], channel [1:0] |
| reg_wdata_i | input | 16 | Register write data |
| dreq_i | input | 4 | Device request per channel |
| hlda_i | input | 1 | Bus grant from the processor |
| hold_o | output | 1 | Bus request to the processor |
| dack_o | output | 4 | Acknowledge per channel |
| addr_o | output | 16+PAGE_W | Bus address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |
| status_o | output | 8 | Request bits [7:4], terminal-count bits [3:0] |

## Verification
Two functions can meet in one cycle: the priority choice and a block transfer that is still running. A higher-priority channel can start requesting while a lower-priority channel is halfway through its block. The bench provokes this by raising channel 0's request right after channel 2 has moved its first byte. It then judges the logged order of bus cycles: all four bytes of channel 2 must come before the single byte of channel 0, with a HOLD gap between the two services. The same log is used to check that a demand request dropped mid-block stops the transfer on the very next cycle.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int NCH   = 4;
  localparam int CH_W  = 2;
  localparam int ADR_W = 16;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    MODE_DEMAND = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_BLOCK2 = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HREQ = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam logic [1:0] FN_ADDR = 2'd0;
  localparam logic [1:0] FN_CNT  = 2'd1;
  localparam logic [1:0] FN_CFG  = 2'd2;
  localparam logic [1:0] FN_CTL  = 2'd3;
  localparam logic [1:0] CTL_SWREQ = 2'd0;
  localparam logic [1:0] CTL_MASK1 = 2'd1;
  localparam logic [1:0] CTL_MASKA = 2'd2;
endpackage

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan
  import dma_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic              wr_cfg_i,
  input  logic [15:0]       wdata_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              mask_load_i,
  input  logic              mask_val_i,
  input  logic              sw_set_i,
  input  logic              sw_clr_i,
  input  logic              step_i,
  input  logic              dreq_i,
  output logic [ADR_W-1:0]  addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output xfer_mode_e        mode_o,
  output logic              dir_o,
  output logic              tc_o,
  output logic              req_o,
  output logic              elig_o
);
  logic [ADR_W-1:0]  addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  xfer_mode_e        mode_q;
  logic              dir_q, tc_q, mask_q, sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      page_q <= '0;
      mode_q <= MODE_DEMAND;
      dir_q  <= 1'b0;
      tc_q   <= 1'b0;
      mask_q <= 1'b1;
      sw_q   <= 1'b0;
    end else begin
      if (wr_addr_i)   addr_q <= wdata_i[ADR_W-1:0];
      else if (step_i) addr_q <= addr_q + 1'b1;
      if (wr_cnt_i)    cnt_q  <= wdata_i[CNT_W-1:0];
      else if (step_i) cnt_q  <= cnt_q - 1'b1;
      if (wr_cnt_i)                     tc_q <= 1'b0;
      else if (step_i && cnt_q == 1)    tc_q <= 1'b1;
      if (wr_cfg_i) begin
        page_q <= wdata_i[PAGE_W-1:0];
        mode_q <= xfer_mode_e'(wdata_i[9:8]);
        dir_q  <= wdata_i[10];
      end
      if (mask_load_i)     mask_q <= mask_val_i;
      else if (mask_set_i) mask_q <= 1'b1;
      else if (mask_clr_i) mask_q <= 1'b0;
      if (sw_clr_i) sw_q <= 1'b0;
      if (sw_set_i) sw_q <= 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign page_o = page_q;
  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign tc_o   = tc_q;
  assign req_o  = dreq_i | sw_q;
  assign elig_o = req_o && !mask_q && (cnt_q != '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q != '0); // R2
endmodule

// File: rtl/dma_arb.sv
`timescale 1ns/1ps
module dma_arb
  import dma_pkg::*;
(
  input  logic [NCH-1:0]  elig_i,
  output logic [CH_W-1:0] idx_o,
  output logic            any_o
);
  logic [NCH-1:0] below;

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        idx_o = CH_W'(i);
        any_o = 1'b1;
      end
    end
  end

  assign below = (NCH'(1) << idx_o) - NCH'(1);

  always_comb begin
    if (any_o) begin
      AST_GNT_ELIGIBLE: assert (elig_i[idx_o]); // R12
      AST_GNT_LOWEST: assert ((elig_i & below) == '0); // R12
    end
  end
endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [CH_W-1:0]  idx_i,
  input  logic             hlda_i,
  input  xfer_mode_e       mode_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hold_o,
  output logic             xfer_o,
  output logic             step_o,
  output logic             done_o,
  output logic [CH_W-1:0]  ch_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] ch_q;
  logic            go, last;

  assign go     = (mode_i != MODE_DEMAND) || req_i;
  assign last   = (cnt_i == 1) || (mode_i == MODE_SINGLE);
  assign xfer_o = state_q == ST_XFER;
  assign step_o = xfer_o && go;
  assign done_o = state_q == ST_DONE;
  assign hold_o = (state_q == ST_HREQ) || xfer_o;
  assign ch_o   = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_i) begin
          state_q <= ST_HREQ;
          ch_q    <= idx_i;
        end
        ST_HREQ: if (hlda_i) state_q <= ST_XFER;
        ST_XFER: if (!go || last) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HREQ && !hlda_i) |=> !xfer_o); // R3
  AST_BLOCK_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && mode_i[1] && cnt_i != 1) |=> step_o); // R5
  AST_SINGLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && mode_i == MODE_SINGLE) |=> !hold_o); // R6
  AST_DEMAND_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && mode_i == MODE_DEMAND && !req_i) |=> !hold_o); // R7
  AST_HOLD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_o) |-> !hold_o); // R12
endmodule

// File: rtl/dma_ctrl.sv
`timescale 1ns/1ps
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [3:0]              reg_addr_i,
  input  logic [15:0]             reg_wdata_i,
  input  logic [3:0]              dreq_i,
  input  logic                    hlda_i,
  output logic                    hold_o,
  output logic [3:0]              dack_o,
  output logic [ADR_W+PAGE_W-1:0] addr_o,
  output logic                    mem_rd_o,
  output logic                    mem_wr_o,
  output logic                    io_rd_o,
  output logic                    io_wr_o,
  output logic [7:0]              status_o
);
  logic [ADR_W-1:0]  addr_a [NCH];
  logic [CNT_W-1:0]  cnt_a  [NCH];
  logic [PAGE_W-1:0] page_a [NCH];
  xfer_mode_e        mode_a [NCH];
  logic [NCH-1:0]    dir_v, tc_v, req_v, elig_v;

  logic [1:0]      fn;
  logic [CH_W-1:0] rch;
  logic            ctl_we;
  logic [CH_W-1:0] idx, ch_sel;
  logic            any, xfer, step, done;

  assign fn     = reg_addr_i[3:2];
  assign rch    = reg_addr_i[1:0];
  assign ctl_we = reg_we_i && fn == FN_CTL;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, ctl_hit;
    assign hit     = reg_we_i && rch == CH_W'(c);
    assign ctl_hit = reg_wdata_i[1:0] == CH_W'(c);

    dma_chan #(.PAGE_W(PAGE_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (hit && fn == FN_ADDR),
      .wr_cnt_i   (hit && fn == FN_CNT),
      .wr_cfg_i   (hit && fn == FN_CFG),
      .wdata_i    (reg_wdata_i),
      .mask_set_i (ctl_we && rch == CTL_MASK1 && ctl_hit && reg_wdata_i[2]),
      .mask_clr_i (ctl_we && rch == CTL_MASK1 && ctl_hit && !reg_wdata_i[2]),
      .mask_load_i(ctl_we && rch == CTL_MASKA),
      .mask_val_i (reg_wdata_i[c]),
      .sw_set_i   (ctl_we && rch == CTL_SWREQ && ctl_hit && reg_wdata_i[2]),
      .sw_clr_i   (done && ch_sel == CH_W'(c)),
      .step_i     (step && ch_sel == CH_W'(c)),
      .dreq_i     (dreq_i[c]),
      .addr_o     (addr_a[c]),
      .cnt_o      (cnt_a[c]),
      .page_o     (page_a[c]),
      .mode_o     (mode_a[c]),
      .dir_o      (dir_v[c]),
      .tc_o       (tc_v[c]),
      .req_o      (req_v[c]),
      .elig_o     (elig_v[c])
    );
  end

  dma_arb u_arb (
    .elig_i(elig_v),
    .idx_o (idx),
    .any_o (any)
  );

  dma_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .any_i (any),
    .idx_i (idx),
    .hlda_i(hlda_i),
    .mode_i(mode_a[ch_sel]),
    .req_i (req_v[ch_sel]),
    .cnt_i (cnt_a[ch_sel]),
    .hold_o(hold_o),
    .xfer_o(xfer),
    .step_o(step),
    .done_o(done),
    .ch_o  (ch_sel)
  );

  assign dack_o   = xfer ? (NCH'(1) << ch_sel) : '0;
  assign addr_o   = {page_a[ch_sel], addr_a[ch_sel]};
  assign mem_rd_o = step && !dir_v[ch_sel];
  assign io_wr_o  = step && !dir_v[ch_sel];
  assign mem_wr_o = step && dir_v[ch_sel];
  assign io_rd_o  = step && dir_v[ch_sel];
  assign status_o = {req_v, tc_v};

  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o)); // R4
  AST_DACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dack_o) |-> hold_o); // R3
  AST_STROBE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o)); // R4
endmodule

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  raddr;
  logic [15:0] wdata;
  logic [3:0]  dreq;
  logic        hlda;
  logic        hold;
  logic [3:0]  dack;
  logic [23:0] addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;
  int bytes [4];
  logic [15:0] exp_addr [4];
  logic [7:0]  exp_page [4];
  logic        exp_dir  [4];
  int log_ch [64];
  int log_n = 0;
  logic prev_x = 1'b0;

  always #5 clk = ~clk;

  dma_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .dreq_i(dreq), .hlda_i(hlda), .hold_o(hold),
    .dack_o(dack), .addr_o(addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .status_o(status)
  );

  // bus owner grants one cycle after the request
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= hold;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(dack) > 1) chk(0, "R4 dack onehot", int'(dack), 0);
      if (mem_rd || mem_wr) begin
        int ch;
        ch = 0;
        for (int i = 0; i < 4; i++) if (dack[i]) ch = i;
        chk(dack != 0, "R4 dack during cycle", int'(dack), 1);
        chk(hlda, "R3 cycle needs grant", int'(hlda), 1);
        chk(addr == {exp_page[ch], exp_addr[ch]}, "R1 address", int'(addr),
            int'({exp_page[ch], exp_addr[ch]}));
        chk(exp_dir[ch] ? (io_rd && mem_wr && !mem_rd && !io_wr)
                        : (mem_rd && io_wr && !mem_wr && !io_rd),
            "R4 direction", int'({mem_rd, mem_wr, io_rd, io_wr}), int'(exp_dir[ch]));
        exp_addr[ch] = exp_addr[ch] + 16'd1;
        bytes[ch]++;
        if (log_n < 64) begin
          log_ch[log_n] = ch;
          log_n++;
        end
      end
      if (prev_x && dack == 0) chk(!hold, "R12 hold gap", int'(hold), 0);
      prev_x = |dack;
    end
  end

  task automatic wr(input logic [1:0] fn, input logic [1:0] ch, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; raddr = {fn, ch}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] base, input logic [15:0] cnt,
                      input logic [7:0] page, input logic [1:0] mode, input logic dir);
    wr(2'd0, 2'(ch), base);
    wr(2'd1, 2'(ch), cnt);
    wr(2'd2, 2'(ch), {5'b0, dir, mode, page});
    exp_addr[ch] = base;
    exp_page[ch] = page;
    exp_dir[ch]  = dir;
    bytes[ch]    = 0;
  endtask

  task automatic unmask(input int ch);
    wr(2'd3, 2'd1, 16'(ch));
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); dreq[ch] = 1'b1;
    @(negedge clk); dreq[ch] = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (!hold && dack == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic no_hold(input string req, input int cycles);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hold) seen = 1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      bytes[i] = 0; exp_addr[i] = '0; exp_page[i] = '0; exp_dir[i] = 1'b0;
    end
    rst_n = 1'b0; we = 1'b0; raddr = '0; wdata = '0; dreq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hold && dack == 0, "R3 reset outputs", int'({hold, dack}), 0);
    chk(!mem_rd && !mem_wr && !io_rd && !io_wr, "R3 reset strobes",
        int'({mem_rd, mem_wr, io_rd, io_wr}), 0);
    chk(status == 8'h00, "R8 reset status", int'(status), 0);

    // masked after reset: request is seen in status but not served
    prog(0, 16'h0100, 16'd2, 8'h01, 2'd2, 1'b0);
    @(negedge clk); dreq[0] = 1'b1;
    @(negedge clk);
    chk(status[4] == 1'b1, "R8 request bit while masked", int'(status), 8'h10);
    no_hold("R10 reset mask blocks", 10);
    dreq[0] = 1'b0;

    // block sweep over every channel and counts 1..4
    for (int ch = 0; ch < 4; ch++) begin
      unmask(ch);
      for (int n = 1; n <= 4; n++) begin
        prog(ch, 16'(ch * 16'h1000 + n * 16'h0100 + 16'h00F0), 16'(n),
             8'(ch * 16 + n), 2'd2, n[0]);
        pulse(ch);
        wait_idle();
        chk(bytes[ch] == n, "R5 block count", bytes[ch], n);
        chk(status[ch] == 1'b1, "R2 terminal count set", int'(status), 1 << ch);
        wr(2'd1, 2'(ch), 16'd0);
        chk(status[ch] == 1'b0, "R2 count write clears tc", int'(status), 0);
      end
    end

    // count zero never starts
    prog(0, 16'h2000, 16'd0, 8'h00, 2'd2, 1'b0);
    pulse(0);
    no_hold("R2 zero count idle", 8);
    chk(bytes[0] == 0, "R2 zero count bytes", bytes[0], 0);

    // address wrap inside the page
    prog(1, 16'hFFFE, 16'd3, 8'hAB, 2'd3, 1'b1);
    pulse(1);
    wait_idle();
    chk(bytes[1] == 3, "R1 wrap byte count", bytes[1], 3);
    chk(exp_addr[1] == 16'h0001, "R1 wrap end address", int'(exp_addr[1]), 1);

    // single mode: one byte per request, resumes in place
    prog(2, 16'h3000, 16'd5, 8'h22, 2'd1, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      pulse(2);
      wait_idle();
      chk(bytes[2] == k, "R6 one byte per request", bytes[2], k);
      if (k == 3) chk(status[2] == 1'b0, "R6 tc not yet", int'(status), 0);
    end
    chk(status[2] == 1'b1, "R6 tc after last", int'(status), 4);
    pulse(2);
    no_hold("R2 exhausted channel idle", 6);
    chk(bytes[2] == 5, "R6 no extra byte", bytes[2], 5);

    // demand mode: stop on drop, resume in place
    prog(3, 16'h4000, 16'd10, 8'h33, 2'd0, 1'b0);
    @(negedge clk); dreq[3] = 1'b1;
    while (bytes[3] < 3) @(posedge clk);
    #1 dreq[3] = 1'b0;
    wait_idle();
    chk(bytes[3] == 3, "R7 stop on drop", bytes[3], 3);
    chk(status[3] == 1'b0, "R7 no tc on pause", int'(status), 0);
    @(negedge clk); dreq[3] = 1'b1;
    while (bytes[3] < 5) @(posedge clk);
    #1 dreq[3] = 1'b0;
    wait_idle();
    chk(bytes[3] == 5, "R7 resume and stop", bytes[3], 5);
    @(negedge clk); dreq[3] = 1'b1;
    wait_idle();
    chk(bytes[3] == 10, "R7 run to end", bytes[3], 10);
    chk(status[3] == 1'b1, "R7 tc at end", int'(status), 8);
    dreq[3] = 1'b0;

    // priority: simultaneous requests
    prog(1, 16'h5000, 16'd2, 8'h41, 2'd2, 1'b0);
    prog(2, 16'h5100, 16'd2, 8'h42, 2'd2, 1'b1);
    log_n = 0;
    @(negedge clk); dreq[1] = 1'b1; dreq[2] = 1'b1;
    wait_idle();
    dreq[1] = 1'b0; dreq[2] = 1'b0;
    chk(log_n == 4 && log_ch[0] == 1 && log_ch[1] == 1 && log_ch[2] == 2 && log_ch[3] == 2,
        "R12 order 1 then 2", log_ch[0] * 16 + log_ch[2], 16 + 2);
    prog(0, 16'h5200, 16'd1, 8'h40, 2'd2, 1'b0);
    prog(3, 16'h5300, 16'd1, 8'h43, 2'd2, 1'b1);
    unmask(3);
    log_n = 0;
    @(negedge clk); dreq[0] = 1'b1; dreq[3] = 1'b1;
    wait_idle();
    dreq[0] = 1'b0; dreq[3] = 1'b0;
    chk(log_n == 2 && log_ch[0] == 0 && log_ch[1] == 3, "R12 order 0 then 3",
        log_ch[0] * 16 + log_ch[1], 3);

    // higher priority arrives during a running block
    prog(2, 16'h6000, 16'd4, 8'h52, 2'd2, 1'b0);
    prog(0, 16'h6100, 16'd1, 8'h50, 2'd2, 1'b1);
    log_n = 0;
    @(negedge clk); dreq[2] = 1'b1;
    while (bytes[2] < 1) @(posedge clk);
    #1 dreq[0] = 1'b1; dreq[2] = 1'b0;
    wait_idle();
    dreq[0] = 1'b0;
    chk(log_n == 5 && log_ch[3] == 2 && log_ch[4] == 0, "R5 block finishes before R12 winner",
        log_ch[3] * 16 + log_ch[4], 2 * 16);

    // software request
    prog(0, 16'h7000, 16'd3, 8'h60, 2'd2, 1'b0);
    wr(2'd3, 2'd0, 16'h0004);
    wait_idle();
    chk(bytes[0] == 3, "R9 software block", bytes[0], 3);
    chk(status[4] == 1'b0, "R9 request cleared", int'(status), 0);
    prog(1, 16'h7100, 16'd4, 8'h61, 2'd1, 1'b1);
    wr(2'd3, 2'd0, 16'h0005);
    wait_idle();
    chk(bytes[1] == 1, "R9 software single", bytes[1], 1);
    chk(status[5] == 1'b0, "R9 single request cleared", int'(status), 0);

    // single-channel mask set, software request held while masked
    prog(3, 16'h7300, 16'd2, 8'h63, 2'd2, 1'b0);
    wr(2'd3, 2'd1, 16'h0007);
    wr(2'd3, 2'd0, 16'h0007);
    chk(status[7] == 1'b1, "R8 software request visible", int'(status), 8'h80);
    no_hold("R10 masked channel idle", 8);
    unmask(3);
    wait_idle();
    chk(bytes[3] == 2, "R10 unmask starts service", bytes[3], 2);

    // mask-all register
    wr(2'd3, 2'd2, 16'h000F);
    prog(2, 16'h7200, 16'd2, 8'h62, 2'd2, 1'b1);
    @(negedge clk); dreq[2] = 1'b1;
    no_hold("R11 all masked", 8);
    chk(bytes[2] == 0, "R11 no bytes while masked", bytes[2], 0);
    wr(2'd3, 2'd2, 16'h000B);
    wait_idle();
    dreq[2] = 1'b0;
    chk(bytes[2] == 2, "R11 unmask by bit 2", bytes[2], 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule